// File: doc/BRIEF.md
# Phase-Encoded Block Framer

This block lays out the 9-track character stream for one phase-encoded record written at 1600 bpi. A record is framed front and back by matching bursts. The leading burst is a run of all-zero characters closed by a single all-ones character. The trailing burst is the same run in reverse order. Between the two bursts, each byte taken from the upstream source goes out with an odd parity bit on the ninth track.

On request the block also writes a file mark. When the tape sits at load point, it first writes an identification burst ahead of the record, in which only the parity track carries flux. Characters leave at the rate set by a character-clock enable. Each character comes with a per-track erase mask that tells the write channel which tracks to leave unmagnetised.

An optional stage turns every character into two half-cell levels per track. Bytes arrive over a valid/ready handshake that is paced by the character clock.

Top module: `pe_block_framer`

## Requirements
- R1: While reset is held and in the first cycle after it, `ch_valid`, `done`, `busy` and `in_ready` are all low.
- R2: A character (`ch_valid` high for one cycle, in the cycle after the enabling edge) appears only for a `char_tick` seen while an operation is active, with at most one character per tick. Nothing is emitted while idle.
- R3: A record begins with AMBLE_ZEROS characters of value 9'h000, followed by one character of 9'h1FF, all with erase mask 0.
- R4: Each data character carries the byte on bits 7..0 and, on bit 8, the parity bit that makes the count of ones in the 9 bits odd. Its erase mask is 0.
- R5: After the byte flagged `in_last`, the block emits one 9'h1FF character, then AMBLE_ZEROS characters of 9'h000 with erase mask 0. `done` is high together with the final character, and `busy` is low from that point on.
- R6: If `at_bot` is high in the cycle that `start_rec` is accepted, ID_CHARS characters come before the leading burst. In these, bits 7..0 are 0 and bit 8 is 1, 0, 1, … starting with 1, and the erase mask is 9'h0FF (tracks 0..7 erased).
- R7: `start_mark` produces AMBLE_ZEROS characters of 9'h000 with erase mask 9'h01A (tracks 1, 3 and 4 erased). `done` is high with the last of them.
- R8: `in_ready` is high only in the data phase while `char_tick` is high, and a byte is consumed when `in_valid` and `in_ready` are both high. A tick in the data phase with `in_valid` low emits nothing.
- R9: `start_rec` and `start_mark` are ignored while `busy` is high. When both are raised together in idle, the record is started.
- R10: With ENCODE=1, for each track of the current character: a written 1 gives `cell_first`=0, `cell_second`=1; a written 0 gives 1, 0; an erased track gives 0, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_tick | input | 1 | Character-clock enable |
| start_rec | input | 1 | Start a data record |
| start_mark | input | 1 | Start a file mark |
| at_bot | input | 1 | Tape is at load point (sampled with start_rec) |
| in_byte | input | 8 | Data byte from source |
| in_valid | input | 1 | in_byte is valid |
| in_last | input | 1 | in_byte is the last byte of the record |
| in_ready | output | 1 | Byte is taken this cycle when in_valid is high |
| busy | output | 1 | An operation is in progress |
| ch_valid | output | 1 | ch_data/ch_erase hold a new character |
| ch_data | output | 9 | Character, bit 8 = parity track |
| ch_erase | output | 9 | Per-track erase mask, 1 = leave track erased |
| done | output | 1 | Pulse with the last character of a record or mark |
| cell_first | output | 9 | First half-cell level per track |
| cell_second | output | 9 | Second half-cell level per track |

## Verification
The bench builds the block with AMBLE_ZEROS=40, the true burst length, so the boundary counts of both bursts and of the file mark are checked at full size. ID_CHARS is set to 7, an odd value, so the identification burst has to end on a parity-track one; a wrong start phase or an off-by-one length would show. ENCODE=1 brings the half-cell stage into every comparison. Different tick spacings and source stalls that land on ticks exercise the paced handshake. Start requests injected mid-record, and start requests raised together, reach the ignore and priority rules.

// File: rtl/pe_framer_pkg.sv
// Package: shared state type and character constants for the phase-encoded
// framer. Assumes a 9-track character with bit 8 as the parity track.
package pe_framer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IDB,
        ST_PRE,
        ST_DATA,
        ST_POST,
        ST_MARK
    } fr_state_t;

    localparam logic [8:0] CHR_ONES   = 9'h1FF;
    localparam logic [8:0] CHR_ZERO   = 9'h000;
    localparam logic [8:0] ERA_NONE   = 9'h000;
    localparam logic [8:0] ERA_IDB    = 9'h0FF;
    localparam logic [8:0] ERA_MARK   = 9'h01A;

    // Odd parity bit for one byte
    function automatic logic odd_par(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/pe_frame_seq.sv
// Module: phase sequencer. Walks idle -> (ID burst) -> leading burst -> data
// -> trailing burst, or idle -> file mark, advancing one character per tick.
// Assumes ID_CHARS >= 1 and AMBLE_ZEROS >= 1; starts are taken only in idle.
module pe_frame_seq
    import pe_framer_pkg::*;
#(
    parameter int AMBLE_ZEROS = 40,
    parameter int ID_CHARS    = 48,
    parameter int CW          = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_tick,
    input  logic          start_rec,
    input  logic          start_mark,
    input  logic          at_bot,
    input  logic          in_valid,
    input  logic          in_last,
    output logic          in_ready,
    output logic          emit,
    output logic          finish,
    output logic          busy,
    output fr_state_t     state_o,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] K_AMB  = CW'(AMBLE_ZEROS);
    localparam logic [CW-1:0] K_AMBL = CW'(AMBLE_ZEROS - 1);
    localparam logic [CW-1:0] K_IDL  = CW'(ID_CHARS - 1);

    fr_state_t     state;
    logic [CW-1:0] cnt;
    logic          last_here;
    fr_state_t     nxt_phase;

    // Decide whether this tick produces a character
    always_comb begin
        unique case (state)
            ST_IDB, ST_PRE, ST_POST, ST_MARK: emit = char_tick;
            ST_DATA:                          emit = char_tick && in_valid;
            default:                          emit = 1'b0;
        endcase
    end

    // Detect the final character of the current phase and its successor
    always_comb begin
        last_here = 1'b0;
        nxt_phase = ST_IDLE;
        unique case (state)
            ST_IDB:  begin last_here = (cnt == K_IDL);  nxt_phase = ST_PRE;  end
            ST_PRE:  begin last_here = (cnt == K_AMB);  nxt_phase = ST_DATA; end
            ST_DATA: begin last_here = in_last;         nxt_phase = ST_POST; end
            ST_POST: begin last_here = (cnt == K_AMB);  nxt_phase = ST_IDLE; end
            ST_MARK: begin last_here = (cnt == K_AMBL); nxt_phase = ST_IDLE; end
            default: begin last_here = 1'b0;            nxt_phase = ST_IDLE; end
        endcase
    end

    assign in_ready = (state == ST_DATA) && char_tick;
    assign finish   = emit && last_here && (state == ST_POST || state == ST_MARK);
    assign busy     = (state != ST_IDLE);
    assign state_o  = state;
    assign cnt_o    = cnt;

    // Phase register and position counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (state == ST_IDLE) begin
            cnt <= '0;
            if (start_rec)       state <= at_bot ? ST_IDB : ST_PRE;
            else if (start_mark) state <= ST_MARK;
        end else if (emit) begin
            if (last_here) begin
                cnt   <= '0;
                state <= nxt_phase;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= K_AMB || cnt <= K_IDL);  // R3
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !char_tick) |=> ($stable(state) && $stable(cnt)));  // R2

endmodule

// File: rtl/pe_char_mux.sv
// Module: character former. Maps phase, position and input byte to the 9-bit
// character and the per-track erase mask. Purely combinational.
module pe_char_mux
    import pe_framer_pkg::*;
#(
    parameter int AMBLE_ZEROS = 40,
    parameter int CW          = 6
) (
    input  fr_state_t     state,
    input  logic [CW-1:0] cnt,
    input  logic [7:0]    in_byte,
    output logic [8:0]    chr,
    output logic [8:0]    era
);

    localparam logic [CW-1:0] K_AMB = CW'(AMBLE_ZEROS);

    // Select the character and erase pattern for the current position
    always_comb begin
        chr = CHR_ZERO;
        era = ERA_NONE;
        unique case (state)
            ST_IDB:  begin chr = {~cnt[0], 8'h00}; era = ERA_IDB; end
            ST_PRE:  chr = (cnt == K_AMB) ? CHR_ONES : CHR_ZERO;
            ST_DATA: chr = {odd_par(in_byte), in_byte};
            ST_POST: chr = (cnt == '0) ? CHR_ONES : CHR_ZERO;
            ST_MARK: era = ERA_MARK;
            default: chr = CHR_ZERO;
        endcase
    end

endmodule

// File: rtl/pe_cell_encoder.sv
// Module: half-cell encoder. For each track, a one is low-then-high, a zero is
// high-then-low, an erased track stays low in both halves. ENCODE=0 removes it.
module pe_cell_encoder #(
    parameter int TRACKS = 9,
    parameter bit ENCODE = 1'b1
) (
    input  logic [TRACKS-1:0] chr,
    input  logic [TRACKS-1:0] era,
    output logic [TRACKS-1:0] first_half,
    output logic [TRACKS-1:0] second_half
);

    if (ENCODE) begin : g_enc
        for (genvar t = 0; t < TRACKS; t++) begin : g_trk
            // Mid-cell transition direction carries the bit value
            assign first_half[t]  = !era[t] && !chr[t];
            assign second_half[t] = !era[t] &&  chr[t];
        end
    end else begin : g_off
        logic unused_ok;
        assign unused_ok   = ^{chr, era};
        assign first_half  = '0;
        assign second_half = '0;
    end

endmodule

// File: rtl/pe_block_framer.sv
// Module: top of the phase-encoded block framer. Registers one character plus
// erase mask per accepted tick and drives the optional half-cell stage.
// Assumes the source presents bytes on in_byte/in_valid paced by char_tick.
module pe_block_framer
    import pe_framer_pkg::*;
#(
    parameter int AMBLE_ZEROS = 40,
    parameter int ID_CHARS    = 48,
    parameter bit ENCODE      = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       char_tick,
    input  logic       start_rec,
    input  logic       start_mark,
    input  logic       at_bot,
    input  logic [7:0] in_byte,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic       busy,
    output logic       ch_valid,
    output logic [8:0] ch_data,
    output logic [8:0] ch_erase,
    output logic       done,
    output logic [8:0] cell_first,
    output logic [8:0] cell_second
);

    localparam int MAXC = (AMBLE_ZEROS + 1 > ID_CHARS) ? AMBLE_ZEROS + 1 : ID_CHARS;
    localparam int CW   = $clog2(MAXC + 1);

    fr_state_t     state;
    logic [CW-1:0] cnt;
    logic          emit;
    logic          finish;
    logic [8:0]    nxt_chr;
    logic [8:0]    nxt_era;

    pe_frame_seq #(
        .AMBLE_ZEROS(AMBLE_ZEROS),
        .ID_CHARS   (ID_CHARS),
        .CW         (CW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_tick (char_tick),
        .start_rec (start_rec),
        .start_mark(start_mark),
        .at_bot    (at_bot),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .emit      (emit),
        .finish    (finish),
        .busy      (busy),
        .state_o   (state),
        .cnt_o     (cnt)
    );

    pe_char_mux #(
        .AMBLE_ZEROS(AMBLE_ZEROS),
        .CW         (CW)
    ) u_mux (
        .state  (state),
        .cnt    (cnt),
        .in_byte(in_byte),
        .chr    (nxt_chr),
        .era    (nxt_era)
    );

    // Output character register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_valid <= 1'b0;
            ch_data  <= '0;
            ch_erase <= '0;
            done     <= 1'b0;
        end else begin
            ch_valid <= emit;
            done     <= finish;
            if (emit) begin
                ch_data  <= nxt_chr;
                ch_erase <= nxt_era;
            end
        end
    end

    pe_cell_encoder #(
        .TRACKS(9),
        .ENCODE(ENCODE)
    ) u_enc (
        .chr        (ch_data),
        .era        (ch_erase),
        .first_half (cell_first),
        .second_half(cell_second)
    );

    AST_TICK_BEFORE_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> $past(char_tick));  // R2
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> !ch_valid);  // R2
    AST_DATA_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && $past(in_ready && in_valid)) |-> (^ch_data));  // R4
    AST_DONE_ON_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ch_valid);  // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R5
    AST_ERASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> (ch_erase == ERA_NONE || ch_erase == ERA_IDB || ch_erase == ERA_MARK));  // R7
    AST_ID_TRACKS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && ch_erase == ERA_IDB) |-> (ch_data[7:0] == 8'h00));  // R6

endmodule

// File: tb/pe_block_framer_test.sv
module pe_block_framer_test;

    localparam int CLK_PERIOD = 10;
    localparam int AMB        = 40;
    localparam int ID_N       = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_tick = 1'b0;
    logic       start_rec = 1'b0;
    logic       start_mark = 1'b0;
    logic       at_bot = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready, busy, ch_valid, done;
    logic [8:0] ch_data, ch_erase, cell_first, cell_second;

    pe_block_framer #(
        .AMBLE_ZEROS(AMB),
        .ID_CHARS   (ID_N),
        .ENCODE     (1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .char_tick(char_tick),
        .start_rec(start_rec), .start_mark(start_mark), .at_bot(at_bot),
        .in_byte(in_byte), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .busy(busy), .ch_valid(ch_valid),
        .ch_data(ch_data), .ch_erase(ch_erase), .done(done),
        .cell_first(cell_first), .cell_second(cell_second)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    bit    done_seen = 1'b0;

    logic [8:0] q_dat[$];
    logic [8:0] q_era[$];
    bit         q_done[$];
    string      q_tag[$];
    logic [7:0] s_byte[$];
    bit         s_last[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_char(input logic [8:0] d, input logic [8:0] e,
                             input bit dn, input string tag);
        q_dat.push_back(d); q_era.push_back(e);
        q_done.push_back(dn); q_tag.push_back(tag);
    endtask

    // Expected stream for one record (R3..R6)
    task automatic plan_record(input bit bot, input int n, input int seed);
        if (bot)
            for (int i = 0; i < ID_N; i++)
                push_char({(i % 2) == 0, 8'h00}, 9'h0FF, 1'b0, "R6");
        for (int i = 0; i < AMB; i++) push_char(9'h000, 9'h000, 1'b0, "R3");
        push_char(9'h1FF, 9'h000, 1'b0, "R3");
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'((seed * 53 + i * 29 + 7) & 255);
            push_char({~(^b), b}, 9'h000, 1'b0, "R4");
            s_byte.push_back(b);
            s_last.push_back(i == n - 1);
        end
        push_char(9'h1FF, 9'h000, 1'b0, "R5");
        for (int i = 0; i < AMB; i++) push_char(9'h000, 9'h000, i == AMB - 1, "R5");
    endtask

    // Expected stream for a file mark (R7)
    task automatic plan_mark();
        for (int i = 0; i < AMB; i++) push_char(9'h000, 9'h01A, i == AMB - 1, "R7");
    endtask

    // Launch one operation and pace it with ticks and source stalls
    task automatic drive_op(input bit rec, input bit mark, input bit bot,
                            input int div, input int stall_mod, input bit inject);
        @(negedge clk);
        done_seen  = 1'b0;
        start_rec  = rec;
        start_mark = mark;
        at_bot     = bot;
        @(negedge clk);
        start_rec  = 1'b0;
        start_mark = 1'b0;
        at_bot     = 1'b0;
        for (int c = 0; c < 20000 && !done_seen; c++) begin
            char_tick  = (c % div) == 0;
            in_valid   = (s_byte.size() > 0) && !(stall_mod > 0 && (c % stall_mod) == 1);
            in_byte    = (s_byte.size() > 0) ? s_byte[0] : 8'h00;
            in_last    = (s_last.size() > 0) ? s_last[0] : 1'b0;
            start_mark = inject && (c == 30);
            start_rec  = inject && (c == 31);
            at_bot     = inject && (c == 31);
            #1;
            if (char_tick && in_valid && in_ready) begin
                void'(s_byte.pop_front());
                void'(s_last.pop_front());
            end
            @(negedge clk);
        end
        char_tick = 1'b0; in_valid = 1'b0; in_last = 1'b0;
        start_rec = 1'b0; start_mark = 1'b0; at_bot = 1'b0;
        check(done_seen, "R5", "operation reached done", done_seen, 1);
        check(busy == 1'b0, "R5", "busy after done", busy, 0);
    endtask

    // Per-cycle comparison of the emitted stream against the expected queues
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            if (ch_valid) begin
                if (q_dat.size() == 0) begin
                    check(1'b0, "R2", "character with none expected", ch_data, 0);
                end else begin
                    logic [8:0] ed, ee, ef, es;
                    bit         edn;
                    string      tg;
                    ed = q_dat.pop_front(); ee = q_era.pop_front();
                    edn = q_done.pop_front(); tg = q_tag.pop_front();
                    check(ch_data == ed, tg, "character", ch_data, ed);
                    check(ch_erase == ee, tg, "erase mask", ch_erase, ee);
                    check(done == edn, tg, "done flag", done, edn);
                    for (int t = 0; t < 9; t++) begin
                        ef[t] = !ee[t] && !ed[t];
                        es[t] = !ee[t] &&  ed[t];
                    end
                    check(cell_first == ef && cell_second == es, "R10", "half cells",
                          {cell_first, cell_second}, {ef, es});
                end
                if (done) done_seen = 1'b1;
            end else if (done) begin
                check(1'b0, "R5", "done without character", done, 0);
            end
            if (in_ready) check(busy, "R8", "ready outside operation", busy, 1);
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        char_tick = 1'b1;
        repeat (4) @(negedge clk);
        check(ch_valid == 0, "R1", "ch_valid in reset", ch_valid, 0);
        check(done == 0, "R1", "done in reset", done, 0);
        check(busy == 0, "R1", "busy in reset", busy, 0);
        check(in_ready == 0, "R1", "in_ready in reset", in_ready, 0);
        rst_n = 1'b1;
        char_tick = 1'b0;
        @(negedge clk);
        check(ch_valid == 0 && busy == 0, "R1", "state after release", {ch_valid, busy}, 0);

        // at load point: ID burst then record, tick every cycle
        plan_record(1'b1, 3, 1);
        drive_op(1'b1, 1'b0, 1'b1, 1, 0, 1'b0);
        // mid-tape record, ticks every other cycle, stalls on ticks (R8)
        plan_record(1'b0, 5, 2);
        drive_op(1'b1, 1'b0, 1'b0, 2, 3, 1'b0);
        // file mark, slow ticks
        plan_mark();
        drive_op(1'b0, 1'b1, 1'b0, 3, 0, 1'b0);
        // both starts at once, record wins; starts mid-operation ignored (R9)
        plan_record(1'b0, 1, 3);
        drive_op(1'b1, 1'b1, 1'b0, 1, 0, 1'b1);
        check(q_dat.size() == 0, "R9", "leftover expected characters", q_dat.size(), 0);
        // file mark with load point raised: burst must not appear (R6 scope)
        plan_mark();
        drive_op(1'b0, 1'b1, 1'b1, 1, 0, 1'b0);

        repeat (5) @(negedge clk);
        check(busy == 0, "R9", "idle after all operations", busy, 0);
        check(q_dat.size() == 0, "R2", "all expected characters seen", q_dat.size(), 0);
        summary();
    end

endmodule